// File: doc/BRIEF.md
# Time-over-threshold transition recorder

This block sits behind one group of strip channels of a multi-channel silicon front-end. Each strip has two discriminators: a low one and a readout one. The block samples both on a slow time-over-threshold period. It does not sample on a separate clock. Instead it counts `MUX` cycles of the faster internal clock and samples when the count wraps. It then scans the `MUX` channels of its group, one channel per internal cycle.

A channel starts to be recorded while its low discriminator is high, provided one of these also holds:
- its own readout discriminator is high, or
- an adjacent strip has both discriminators high.

The adjacent-strip rule keeps neighbour pulse heights for centroid finding. Channels with no activity produce nothing. Each start and each end of a recording goes into a FIFO as one word. The word carries the channel number, the edge type and a sample-period timestamp. The difference between the two stamps gives the high time, and later processing turns that into amplitude.

A spill-start pulse arms the block and clears its state. A spill-end pulse closes every open recording with a flagged trailing word, and the block then stays quiet. If the FIFO is full, words are dropped and a sticky flag is raised. The flag clears only at the next spill start.

Top module: `tot_edge_logger`

## Requirements
- R1: After reset the FIFO is empty (`rd_valid` low) and `fifo_ovf` is low. Until a `spill_start` pulse, no comparator activity produces a word.
- R2: After a `spill_start` pulse, the comparators are sampled once every `MUX` internal cycles. Each sample carries a stamp equal to its index since the spill start, beginning at 0. The words of sample n are readable within two sample periods of its capture.
- R3: A channel that is not being recorded gets a leading word (edge bit 0) in a sample where its low comparator is high and either:
  - its own readout comparator is high, or
  - an adjacent channel has both comparators high.
- R4: No word is produced in either of these cases:
  - a channel with low comparator high but no own or adjacent strike;
  - a readout comparator high while the same channel's low comparator is low.
- R5: A recorded channel gets a trailing word (edge bit 1) in the first sample where its low comparator is low. A fall of the readout comparator alone writes nothing.
- R6: For local channels 0 and `MUX-1`, the adjacent strike can come from the strip beyond the group. `nbr_lo[0]`/`nbr_rd[0]` describe the strip below and `nbr_lo[1]`/`nbr_rd[1]` the strip above.
- R7: Word layout is as follows, and the words of one sample appear in ascending channel order:
  - bit `TSW+CHW+1`: overflow flag
  - bit `TSW+CHW`: edge bit
  - bits `TSW+CHW-1:TSW`: channel number, equal to `BASE` plus the local index
  - bits `TSW-1:0`: stamp
- R8: The stamp saturates at all ones and does not wrap within a spill.
- R9: After a `spill_end` pulse, the next sample writes a trailing word with the overflow flag set, for every recorded channel, carrying that sample's stamp. After that, no words are written until the next `spill_start`.
- R10: A word arriving while the FIFO holds `FDEPTH` words is dropped and `fifo_ovf` is set. `fifo_ovf` stays set through reads until `spill_start`, which also empties the FIFO.
- R11: `rd_data` shows the oldest word whenever `rd_valid` is high. `rd_en` pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_start | input | 1 | Arms the block, clears stamp, state and FIFO |
| spill_end | input | 1 | Requests closing of open recordings |
| cmp_lo | input | MUX | Low discriminator per local channel |
| cmp_rd | input | MUX | Readout discriminator per local channel |
| nbr_lo | input | 2 | Low discriminators of strips below (bit 0) and above (bit 1) the group |
| nbr_rd | input | 2 | Readout discriminators of those strips |
| rd_en | input | 1 | Pops the head word |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_data | output | TSW+CHW+2 | Head word |
| fifo_ovf | output | 1 | Sticky drop flag |

## Verification
The bench builds the block with `MUX=8`, `BASE=8`, `TSW=4` and `FDEPTH=4`. The 4-bit stamp reaches saturation after fifteen samples, which keeps the timestamp ceiling within a short run. A four-word FIFO overflows when six channels strike in the same sample, which exposes the drop order and the sticky flag. The base of 8 makes channel numbers differ from local indices, and it allows the group-boundary neighbour inputs to be tested at both ends.

// File: rtl/tot_edge_logger.sv
module tot_edge_logger #(
  parameter int MUX    = 8,
  parameter int BASE   = 0,
  parameter int CHW    = 7,
  parameter int TSW    = 12,
  parameter int FDEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spill_start,
  input  logic                   spill_end,
  input  logic [MUX-1:0]         cmp_lo,
  input  logic [MUX-1:0]         cmp_rd,
  input  logic [1:0]             nbr_lo,
  input  logic [1:0]             nbr_rd,
  input  logic                   rd_en,
  output logic                   rd_valid,
  output logic [TSW+CHW+1:0]     rd_data,
  output logic                   fifo_ovf
);
  localparam int SW = (MUX > 1) ? $clog2(MUX) : 1;
  localparam int IW = $clog2(MUX + 2);
  localparam int AW = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
  localparam int WW = TSW + CHW + 2;
  localparam logic [TSW-1:0] TS_MAX = {TSW{1'b1}};
  localparam logic [SW-1:0]  SLOT_LAST = SW'(MUX - 1);
  localparam logic [AW:0]    DEPTH_C = (AW+1)'(FDEPTH);

  logic [SW-1:0]  slot;
  logic           tick;
  logic           live, flush_pend, scan_on, scan_flush;
  logic [MUX+1:0] s_lo, s_rd;
  logic [TSW-1:0] ts, stamp;
  logic [MUX-1:0] rec;

  assign tick = (slot == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 slot <= '0;
    else if (spill_start || tick) slot <= '0;
    else                        slot <= slot + 1'b1;

  // per-slot decision
  logic [IW-1:0]  ix;
  logic           ch_lo, ch_rd, nb_hit, rec_cur;
  logic           lead, trail, fl, wr_req;
  logic [CHW-1:0] ch_num;
  logic [WW-1:0]  wr_word;

  always_comb begin
    ix      = IW'(slot) + IW'(1);
    ch_lo   = s_lo[ix];
    ch_rd   = s_rd[ix];
    nb_hit  = (s_lo[ix - IW'(1)] & s_rd[ix - IW'(1)]) |
              (s_lo[ix + IW'(1)] & s_rd[ix + IW'(1)]);
    rec_cur = rec[slot];
  end

  assign lead    = scan_on && !scan_flush && !rec_cur && ch_lo && (ch_rd || nb_hit);
  assign trail   = scan_on && !scan_flush && rec_cur && !ch_lo;
  assign fl      = scan_on && scan_flush && rec_cur;
  assign wr_req  = lead || trail || fl;
  assign ch_num  = CHW'(BASE) + CHW'(slot);
  assign wr_word = {fl, trail || fl, ch_num, stamp};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      live       <= 1'b0;
      flush_pend <= 1'b0;
      scan_on    <= 1'b0;
      scan_flush <= 1'b0;
      ts         <= '0;
      stamp      <= '0;
      s_lo       <= '0;
      s_rd       <= '0;
      rec        <= '0;
    end else if (spill_start) begin
      live       <= 1'b1;
      flush_pend <= 1'b0;
      scan_on    <= 1'b0;
      scan_flush <= 1'b0;
      ts         <= '0;
      stamp      <= '0;
      s_lo       <= '0;
      s_rd       <= '0;
      rec        <= '0;
    end else begin
      if (spill_end && live) flush_pend <= 1'b1;
      if (tick) begin
        s_lo       <= {nbr_lo[1], cmp_lo, nbr_lo[0]};
        s_rd       <= {nbr_rd[1], cmp_rd, nbr_rd[0]};
        stamp      <= ts;
        if (ts != TS_MAX) ts <= ts + 1'b1;
        scan_on    <= live;
        scan_flush <= flush_pend;
        if (flush_pend) begin
          live       <= 1'b0;
          flush_pend <= 1'b0;
        end
      end
      if (lead)        rec[slot] <= 1'b1;
      if (trail || fl) rec[slot] <= 1'b0;
    end

  // FIFO
  logic [WW-1:0] mem [FDEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, push, pop;

  assign full     = (cnt == DEPTH_C);
  assign push     = wr_req && !full;
  assign pop      = rd_en && (cnt != '0);
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      fifo_ovf <= 1'b0;
    end else if (spill_start) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      fifo_ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(FDEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(FDEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (wr_req && full) fifo_ovf <= 1'b1;
    end

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf && !spill_start |=> fifo_ovf);
  a_r10_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && full && !spill_start |=> fifo_ovf);
  a_r8_ts_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ts == TS_MAX && !spill_start |=> ts == TS_MAX);
  a_r2_stamp_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !spill_start |=> $stable(stamp));
  a_r9_flush_ends_live: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live) |-> scan_flush && !flush_pend);
  a_r11_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !spill_start |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/sim_tot_edge_logger.sv
module sim_tot_edge_logger;
  localparam int MUX = 8, BASE = 8, CHW = 7, TSW = 4, FDEPTH = 4;
  localparam int WW = TSW + CHW + 2;

  logic clk = 0, rst_n = 0, spill_start = 0, spill_end = 0, rd_en = 0;
  logic [MUX-1:0] cmp_lo = '0, cmp_rd = '0;
  logic [1:0] nbr_lo = '0, nbr_rd = '0;
  logic rd_valid, fifo_ovf;
  logic [WW-1:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  tot_edge_logger #(.MUX(MUX), .BASE(BASE), .CHW(CHW), .TSW(TSW), .FDEPTH(FDEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .spill_start(spill_start), .spill_end(spill_end),
    .cmp_lo(cmp_lo), .cmp_rd(cmp_rd), .nbr_lo(nbr_lo), .nbr_rd(nbr_rd),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .fifo_ovf(fifo_ovf));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] word(bit f, bit e, int ch, int st);
    return {f, e, CHW'(ch), TSW'(st)};
  endfunction

  task automatic spill();
    spill_start = 1;
    @(negedge clk);
    spill_start = 0;
  endtask

  task automatic step(bit end_req);
    spill_end = end_req;
    @(negedge clk);
    spill_end = 0;
    repeat (MUX - 1) @(negedge clk);
  endtask

  task automatic pop_expect(string req, logic [WW-1:0] exp);
    chk({req, " valid"}, int'(rd_valid), 1);
    chk({req, " word"}, int'(rd_data), int'(exp));
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle_inputs();
    cmp_lo = '0; cmp_rd = '0; nbr_lo = '0; nbr_rd = '0;
  endtask

  task automatic t_reset();
    cmp_lo = 8'hFF; cmp_rd = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3 * MUX) @(negedge clk);
    chk("R1 empty after reset", int'(rd_valid), 0);
    chk("R1 ovf clear", int'(fifo_ovf), 0);
    idle_inputs();
  endtask

  task automatic t_basic();
    spill();
    cmp_lo = 8'b0010_1100; cmp_rd = 8'b0100_0100;
    step(0);
    cmp_rd = '0;
    step(0);
    cmp_lo = '0;
    step(0);
    step(0);
    pop_expect("R3 R7 lead ch10", word(0, 0, 10, 0));
    pop_expect("R3 neighbour lead ch11", word(0, 0, 11, 0));
    pop_expect("R5 trail ch10", word(0, 1, 10, 2));
    pop_expect("R5 R2 trail ch11", word(0, 1, 11, 2));
    chk("R4 suppressed channels absent", int'(rd_valid), 0);
    chk("R10 no overflow at exact depth", int'(fifo_ovf), 0);
  endtask

  task automatic t_boundary();
    spill();
    cmp_lo = 8'b1100_0001; nbr_lo = 2'b11; nbr_rd = 2'b11;
    step(0);
    idle_inputs();
    step(0);
    step(0);
    pop_expect("R6 lower boundary lead", word(0, 0, 8, 0));
    pop_expect("R6 upper boundary lead", word(0, 0, 15, 0));
    pop_expect("R6 lower boundary trail", word(0, 1, 8, 1));
    pop_expect("R6 upper boundary trail", word(0, 1, 15, 1));
    chk("R4 ch14 without strike absent", int'(rd_valid), 0);
  endtask

  task automatic t_overflow();
    spill();
    cmp_lo = 8'h3F; cmp_rd = 8'h3F;
    step(0);
    step(0);
    chk("R10 ovf raised", int'(fifo_ovf), 1);
    for (int i = 0; i < 4; i++) pop_expect("R10 R7 kept order", word(0, 0, 8 + i, 0));
    chk("R10 dropped words absent", int'(rd_valid), 0);
    chk("R10 ovf sticky after reads", int'(fifo_ovf), 1);
    idle_inputs();
    spill();
    chk("R10 ovf cleared by spill start", int'(fifo_ovf), 0);
    chk("R10 fifo emptied by spill start", int'(rd_valid), 0);
  endtask

  task automatic t_flush();
    spill();
    cmp_lo = 8'b0000_0010; cmp_rd = 8'b0000_0010;
    step(0);
    step(1);
    step(0);
    cmp_lo = 8'b0001_0000; cmp_rd = 8'b0001_0000;
    step(0);
    step(0);
    pop_expect("R9 lead before end", word(0, 0, 9, 0));
    pop_expect("R9 flagged trail", word(1, 1, 9, 1));
    chk("R9 quiet after spill end", int'(rd_valid), 0);
    idle_inputs();
  endtask

  task automatic t_saturate();
    spill();
    repeat (20) step(0);
    cmp_lo = 8'b0000_0001; cmp_rd = 8'b0000_0001;
    step(0);
    idle_inputs();
    step(0);
    step(0);
    pop_expect("R8 saturated lead stamp", word(0, 0, 8, 15));
    pop_expect("R8 saturated trail stamp", word(0, 1, 8, 15));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_boundary();
    t_overflow();
    t_flush();
    t_saturate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule